// File: doc/BRIEF.md
# Word-to-byte asynchronous SRAM bridge

This block sits between a 32-bit memory-mapped host port and an external asynchronous SRAM that has an 8-bit data bus. Each host read or write carries a word address and four byte enables. The bridge turns that request into one SRAM byte cycle for every enabled lane. It walks the enabled lanes from the lowest to the highest and skips the disabled ones. It drives the SRAM address, chip select, output enable, write enable and the shared data bus. On reads it places every returned byte into its own lane of the 32-bit result.

Wait request stays high while the byte cycles run. A read and a write with the same byte enables take the same number of clocks, so narrow reads cost no more than narrow writes. The host therefore sees the SRAM as plain byte-addressable memory for 8-, 16- and 32-bit accesses. Each SRAM cycle lasts a programmable number of clocks. Write enable goes high one clock before the address or data can move.

Top module: `sram_byte_bridge`

## Requirements
- R1: The SRAM byte address of each cycle is the host word address times LANES (4) plus the lane index. The address is WORD_AW+2 = 19 bits wide by default.
- R2: The bridge drives the SRAM data bus only during write transfers. It releases the bus in all other cycles. Output enable is low only during read byte cycles, and write enable is low only during write byte cycles.
- R3: The number of SRAM byte cycles equals the number of set byte enables. The cycles visit the enabled lanes in ascending order.
- R4: A read and a write with the same byte enables hold wait request for the same number of clocks: 1 + K*CYC_CLKS, where K is the number of enabled lanes.
- R5: A write changes only the SRAM bytes of enabled lanes. Bytes behind disabled lanes keep their old value.
- R6: A read returns the byte at address 4*word+i in bits [8i+7:8i] of the read data. Lanes whose byte enable is low read as zero.
- R7: Each SRAM byte cycle lasts CYC_CLKS clocks (default 2). In a write cycle, write enable is low for the first CYC_CLKS-1 clocks and high in the last clock. The address only changes after a clock in which write enable was high.
- R8: Wait request is high from the clock a request appears until the last byte cycle completes. In the following clock, wait request is low and the read-data-valid output pulses for exactly one clock on reads. It stays low on writes.
- R9: A request with all byte enables low runs no SRAM cycle (chip select stays high). It holds wait request for exactly one clock, and a read returns zero.
- R10: While in reset and after reset, chip select, output enable and write enable are high, read-data-valid is low, and wait request is low when no request is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| h_addr | input | WORD_AW (17) | Host word address |
| h_read | input | 1 | Host read request, held until wait request is low |
| h_write | input | 1 | Host write request, held until wait request is low |
| h_be | input | LANES (4) | Host byte enables, one per 8-bit lane |
| h_wdata | input | 8*LANES (32) | Host write data |
| h_rdata | output | 8*LANES (32) | Read data, valid with h_rvalid |
| h_rvalid | output | 1 | One-clock read-data-valid pulse |
| h_wait | output | 1 | Wait request |
| sram_addr | output | WORD_AW+2 (19) | SRAM byte address |
| sram_cs_n | output | 1 | SRAM chip select, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |
| sram_dq | inout | 8 | Shared SRAM data bus |

## Verification
The bench writes 00..0F to sixteen consecutive bytes and reads them back both as bytes and as whole words. A bridge that returned only the low lane, or that placed every byte in lane 0, would produce repeating patterns such as 03,00,00,00 instead of the ascending values.

Other tests use non-contiguous enables such as 0101, single lanes and all-zero enables. A design that counted lanes wrongly, or did not skip disabled ones, would show the wrong number of SRAM cycles or the wrong address order. A design with either fault would also overwrite neighbouring bytes.

Reads and writes of the same size are compared on wait-request length and on the clocks of write-enable and output-enable activity. A design that stretched reads, or kept write enable low into the last clock of a cycle, would fail these comparisons. A shadow memory checks that disabled lanes survive writes and read back as zero.

// File: rtl/sbb_pkg.sv
package sbb_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_XFER = 2'd1,
      ST_DONE = 2'd2
   } sbb_state_t;
endpackage

// File: rtl/sbb_lane_seq.sv
module sbb_lane_seq #(
   parameter int LANES = 4,
   localparam int LW = $clog2(LANES)
) (
   input  logic [LANES-1:0] mask,
   input  logic [LW-1:0]    cur,
   output logic [LW-1:0]    first_lane,
   output logic [LW-1:0]    next_lane,
   output logic             has_next
);
   always_comb begin
      first_lane = '0;
      next_lane  = '0;
      has_next   = 1'b0;
      for (int i = LANES - 1; i >= 0; i--) begin
         if (mask[i]) begin
            first_lane = LW'(i);
            if (i > int'(cur)) begin
               next_lane = LW'(i);
               has_next  = 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/sbb_cycle_timer.sv
module sbb_cycle_timer #(
   parameter int CYC_CLKS = 2,
   localparam int CW = $clog2(CYC_CLKS + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   output logic [CW-1:0] cnt,
   output logic          last,
   output logic          strobe_ok
);
   localparam logic [CW-1:0] LAST_CNT = CW'(CYC_CLKS - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt <= '0;
      else if (!run)            cnt <= '0;
      else if (cnt == LAST_CNT) cnt <= '0;
      else                      cnt <= cnt + 1'b1;
   end

   assign last      = run && (cnt == LAST_CNT);
   assign strobe_ok = run && (cnt != LAST_CNT);
endmodule

// File: rtl/sbb_rd_assembler.sv
module sbb_rd_assembler #(
   parameter int LANES = 4,
   localparam int LW = $clog2(LANES),
   localparam int DW = 8 * LANES
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          capture,
   input  logic [LW-1:0] sel,
   input  logic [7:0]    din,
   output logic [DW-1:0] dout
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                  dout[8*g +: 8] <= '0;
         else if (clear)                              dout[8*g +: 8] <= '0;
         else if (capture && (sel == LW'(g)))         dout[8*g +: 8] <= din;
      end
   end
endmodule

// File: rtl/sram_byte_bridge.sv
module sram_byte_bridge
   import sbb_pkg::*;
#(
   parameter int WORD_AW  = 17,
   parameter int LANES    = 4,
   parameter int CYC_CLKS = 2,
   localparam int LW      = $clog2(LANES),
   localparam int DW      = 8 * LANES,
   localparam int SAW     = WORD_AW + LW,
   localparam int CW      = $clog2(CYC_CLKS + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [WORD_AW-1:0] h_addr,
   input  logic               h_read,
   input  logic               h_write,
   input  logic [LANES-1:0]   h_be,
   input  logic [DW-1:0]      h_wdata,
   output logic [DW-1:0]      h_rdata,
   output logic               h_rvalid,
   output logic               h_wait,
   output logic [SAW-1:0]     sram_addr,
   output logic               sram_cs_n,
   output logic               sram_oe_n,
   output logic               sram_we_n,
   inout  wire  [7:0]         sram_dq
);
   // elaboration-time parameter checks
   if (CYC_CLKS < 2) begin : g_bad_cyc
      $error("CYC_CLKS must be at least 2 so write enable can rise before the address moves");
   end
   if (LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("LANES must be a power of two, at least 2");
   end
   if (WORD_AW < 1) begin : g_bad_aw
      $error("WORD_AW must be positive");
   end

   sbb_state_t         state_q;
   logic               is_wr_q;
   logic [WORD_AW-1:0] word_q;
   logic [LANES-1:0]   be_q;
   logic [DW-1:0]      wdata_q;
   logic [LW-1:0]      lane_q;

   logic               req;
   logic               xfer;
   logic [LW-1:0]      first_lane, next_lane, first_new, next_unused;
   logic               has_next, has_unused;
   logic [CW-1:0]      tcnt;
   logic               tlast, we_window;
   logic [7:0]         wbyte;
   logic               dq_oe;
   logic [7:0]         lane_bytes [LANES];

   assign req  = h_read || h_write;
   assign xfer = (state_q == ST_XFER);

   // lane order for the transfer in flight
   sbb_lane_seq #(.LANES(LANES)) u_seq (
      .mask       (be_q),
      .cur        (lane_q),
      .first_lane (first_lane),
      .next_lane  (next_lane),
      .has_next   (has_next)
   );

   // first lane of an incoming request
   sbb_lane_seq #(.LANES(LANES)) u_seq_in (
      .mask       (h_be),
      .cur        (LW'(LANES - 1)),
      .first_lane (first_new),
      .next_lane  (next_unused),
      .has_next   (has_unused)
   );

   sbb_cycle_timer #(.CYC_CLKS(CYC_CLKS)) u_tmr (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (xfer),
      .cnt       (tcnt),
      .last      (tlast),
      .strobe_ok (we_window)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         is_wr_q <= 1'b0;
         word_q  <= '0;
         be_q    <= '0;
         wdata_q <= '0;
         lane_q  <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (req) begin
                  is_wr_q <= h_write;
                  word_q  <= h_addr;
                  be_q    <= h_be;
                  wdata_q <= h_wdata;
                  lane_q  <= first_new;
                  state_q <= (h_be == '0) ? ST_DONE : ST_XFER;
               end
            end
            ST_XFER: begin
               if (tlast) begin
                  if (has_next) lane_q  <= next_lane;
                  else          state_q <= ST_DONE;
               end
            end
            ST_DONE: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // write byte selection
   for (genvar g = 0; g < LANES; g++) begin : g_wlane
      assign lane_bytes[g] = wdata_q[8*g +: 8];
   end
   assign wbyte = lane_bytes[lane_q];

   // SRAM pin decode
   assign sram_addr = {word_q, lane_q};
   assign sram_cs_n = !xfer;
   assign sram_oe_n = !(xfer && !is_wr_q);
   assign sram_we_n = !(xfer && is_wr_q && we_window);
   assign dq_oe     = xfer && is_wr_q;
   assign sram_dq   = dq_oe ? wbyte : 8'hzz;

   // read data assembly
   sbb_rd_assembler #(.LANES(LANES)) u_asm (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (state_q == ST_IDLE && req),
      .capture (tlast && !is_wr_q),
      .sel     (lane_q),
      .din     (sram_dq),
      .dout    (h_rdata)
   );

   assign h_wait   = req && (state_q != ST_DONE);
   assign h_rvalid = (state_q == ST_DONE) && !is_wr_q;

   logic unused_ok;
   assign unused_ok = ^{first_lane, next_unused, has_unused, tcnt};
endmodule

// File: rtl/sbb_checker.sv
module sbb_checker #(
   parameter int LANES = 4,
   parameter int SAW   = 19,
   localparam int LW   = $clog2(LANES),
   localparam int DW   = 8 * LANES
) (
   input logic             clk,
   input logic             rst_n,
   input logic             h_wait,
   input logic             h_rvalid,
   input logic [DW-1:0]    h_rdata,
   input logic [SAW-1:0]   sram_addr,
   input logic             sram_cs_n,
   input logic             sram_oe_n,
   input logic             sram_we_n,
   input logic             dq_oe,
   input logic [LANES-1:0] be_q
);
   logic [DW-1:0] off_mask;
   always_comb begin
      for (int i = 0; i < LANES; i++) off_mask[8*i +: 8] = {8{!be_q[i]}};
   end

   AST_DRIVE_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> (!sram_cs_n && sram_oe_n)); // R2
   AST_OE_NOT_WITH_WE: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_oe_n |-> (sram_we_n && !dq_oe)); // R2
   AST_WE_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_we_n |-> !sram_cs_n); // R7
   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sram_addr) |-> $past(sram_we_n)); // R7
   AST_WE_LANE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_we_n |-> be_q[sram_addr[LW-1:0]]); // R5
   AST_RVALID_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      h_rvalid |-> !h_wait); // R8
   AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      h_rvalid |=> !h_rvalid); // R8
   AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      h_rvalid |-> ((h_rdata & off_mask) == '0)); // R6
   AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      h_rvalid |=> sram_cs_n); // R8
endmodule

bind sram_byte_bridge sbb_checker #(.LANES(LANES), .SAW(SAW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .h_wait    (h_wait),
   .h_rvalid  (h_rvalid),
   .h_rdata   (h_rdata),
   .sram_addr (sram_addr),
   .sram_cs_n (sram_cs_n),
   .sram_oe_n (sram_oe_n),
   .sram_we_n (sram_we_n),
   .dq_oe     (dq_oe),
   .be_q      (be_q)
);

// File: tb/sim_sram_byte_bridge.sv
module sim_sram_byte_bridge;
   localparam int CLK_PERIOD = 10;
   localparam int N   = 2;
   localparam int MSZ = 1024;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [16:0] h_addr = '0;
   logic        h_read = 1'b0, h_write = 1'b0;
   logic [3:0]  h_be = '0;
   logic [31:0] h_wdata = '0;
   logic [31:0] h_rdata;
   logic        h_rvalid, h_wait;
   logic [18:0] sram_addr;
   logic        sram_cs_n, sram_oe_n, sram_we_n;
   wire  [7:0]  sram_dq;

   always #(CLK_PERIOD/2) clk = ~clk;

   sram_byte_bridge u0 (
      .clk(clk), .rst_n(rst_n), .h_addr(h_addr), .h_read(h_read), .h_write(h_write),
      .h_be(h_be), .h_wdata(h_wdata), .h_rdata(h_rdata), .h_rvalid(h_rvalid),
      .h_wait(h_wait), .sram_addr(sram_addr), .sram_cs_n(sram_cs_n),
      .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n), .sram_dq(sram_dq)
   );

   // SRAM model
   logic [7:0] mem [MSZ];
   logic [7:0] shadow [MSZ];
   assign sram_dq = (!sram_cs_n && !sram_oe_n && sram_we_n) ? mem[sram_addr[9:0]] : 8'hzz;
   always @(posedge clk) if (!sram_cs_n && !sram_we_n) mem[sram_addr[9:0]] <= sram_dq;

   // pin monitor
   int          mon_cyc = 0, mon_we = 0, mon_oe = 0;
   logic [18:0] mon_log [8];
   logic        prev_cs = 1'b1;
   logic [18:0] prev_addr = '0;
   always @(negedge clk) begin
      #2;
      if (rst_n) begin
         if (!sram_cs_n && (prev_cs || sram_addr != prev_addr)) begin
            mon_log[mon_cyc % 8] = sram_addr;
            mon_cyc++;
         end
         if (!sram_we_n) mon_we++;
         if (!sram_oe_n) mon_oe++;
      end
      prev_cs = sram_cs_n;
      prev_addr = sram_addr;
   end

   int checks = 0, fails = 0;

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_read(input int w, input logic [3:0] be);
      logic [31:0] r = '0;
      for (int i = 0; i < 4; i++) if (be[i]) r[8*i +: 8] = shadow[(4*w + i) % MSZ];
      return r;
   endfunction

   task automatic xfer(input bit wr, input int w, input logic [3:0] be,
                       input logic [31:0] wd, output logic [31:0] rd);
      int c0, we0, oe0, waits, k, idx;
      logic rv;
      c0 = mon_cyc; we0 = mon_we; oe0 = mon_oe;
      k = $countones(be);
      @(negedge clk);
      h_addr = 17'(w); h_be = be; h_wdata = wd; h_write = wr; h_read = !wr;
      #1;
      waits = 0;
      while (h_wait && waits < 1000) begin
         waits++;
         @(negedge clk); #1;
      end
      rd = h_rdata; rv = h_rvalid;
      h_read = 1'b0; h_write = 1'b0;
      @(negedge clk); #3;
      check(waits == 1 + k*N, "R4/R8 wait length", 32'(waits), 32'(1 + k*N));
      check(rv == !wr, "R8 rvalid pulse", 32'(rv), 32'(!wr));
      check(mon_cyc - c0 == k, "R3 byte cycle count", 32'(mon_cyc - c0), 32'(k));
      check(mon_we - we0 == (wr ? k*(N-1) : 0), "R7 write enable clocks",
            32'(mon_we - we0), 32'(wr ? k*(N-1) : 0));
      check(mon_oe - oe0 == (wr ? 0 : k*N), "R2 output enable clocks",
            32'(mon_oe - oe0), 32'(wr ? 0 : k*N));
      idx = c0;
      for (int i = 0; i < 4; i++) begin
         if (be[i]) begin
            check(mon_log[idx % 8] == 19'(4*w + i), "R1/R3 byte address order",
                  32'(mon_log[idx % 8]), 32'(4*w + i));
            idx++;
         end
      end
      if (wr) begin
         for (int i = 0; i < 4; i++) if (be[i]) shadow[(4*w + i) % MSZ] = wd[8*i +: 8];
      end else begin
         check(rd == exp_read(w, be), "R6 read lanes", rd, exp_read(w, be));
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      logic [31:0] rd;
      void'($urandom(32'h5EED));
      for (int i = 0; i < MSZ; i++) begin
         mem[i] = 8'(i * 37 + 11);
         shadow[i] = mem[i];
      end
      // R10 reset state
      repeat (3) @(negedge clk);
      check(sram_cs_n && sram_oe_n && sram_we_n, "R10 pins idle in reset",
            {29'd0, sram_cs_n, sram_oe_n, sram_we_n}, 32'h7);
      check(!h_wait && !h_rvalid, "R10 wait/rvalid in reset", {30'd0, h_wait, h_rvalid}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk); #1;
      check(!h_wait && !h_rvalid && sram_cs_n, "R10 idle after reset",
            {29'd0, h_wait, h_rvalid, sram_cs_n}, 32'h1);

      // byte writes 00..0F, then read back per byte and per word (R6)
      for (int b = 0; b < 16; b++) xfer(1'b1, 16 + b/4, 4'(1 << (b%4)), {4{8'(b)}}, rd);
      for (int b = 0; b < 16; b++) begin
         xfer(1'b0, 16 + b/4, 4'(1 << (b%4)), 32'h0, rd);
         check(rd[8*(b%4) +: 8] == 8'(b), "R6 byte lane value", 32'(rd[8*(b%4) +: 8]), 32'(b));
      end
      for (int w = 0; w < 4; w++) begin
         xfer(1'b0, 16 + w, 4'hF, 32'h0, rd);
         check(rd == {8'(4*w+3), 8'(4*w+2), 8'(4*w+1), 8'(4*w)}, "R6 word of bytes",
               rd, {8'(4*w+3), 8'(4*w+2), 8'(4*w+1), 8'(4*w)});
      end

      // halfword and sparse enables, disabled lanes preserved (R5)
      xfer(1'b1, 40, 4'hF, 32'hA1B2C3D4, rd);
      xfer(1'b1, 40, 4'b0011, 32'h11223344, rd);
      xfer(1'b1, 40, 4'b0100, 32'h55667788, rd);
      xfer(1'b0, 40, 4'hF, 32'h0, rd);
      check(rd == 32'hA1663344, "R5 disabled lanes unchanged", rd, 32'hA1663344);
      xfer(1'b1, 41, 4'b0101, 32'hDEADBEEF, rd);
      xfer(1'b0, 41, 4'b1010, 32'h0, rd);
      xfer(1'b0, 41, 4'b0101, 32'h0, rd);
      check(rd == 32'h00AD00EF, "R6 sparse read zero lanes", rd, 32'h00AD00EF);

      // all enables low (R9)
      xfer(1'b1, 42, 4'h0, 32'hFFFFFFFF, rd);
      xfer(1'b0, 42, 4'h0, 32'h0, rd);
      check(rd == 32'h0, "R9 zero-enable read data", rd, 32'h0);
      xfer(1'b0, 42, 4'hF, 32'h0, rd);

      // random mix
      for (int n = 0; n < 80; n++) begin
         bit wr = 1'($urandom % 2);
         int w = int'($urandom % 256);
         logic [3:0] be = 4'($urandom % 16);
         xfer(wr, w, be, $urandom, rd);
      end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule